// File: doc/BRIEF.md
# Delayed Interrupt Coalescing Controller

This block is the interrupt front end of a DMA engine. Each transmit queue and each receive queue reports completed work with a single-cycle done pulse. Each pulse sets a sticky bit in a status register. Software clears a status bit by writing 1 to it. A mask register selects which status bits may drive the single interrupt line.

The block has one coalescing unit for the transmit direction and one for the receive direction. While a unit is enabled, it counts cycles that carry done pulses for its direction. It also runs a timer that starts with the first pending event. The timer advances on a tick from a shared prescaler. When the count reaches its threshold, or the timer reaches its timeout, the unit sets a delayed-interrupt status bit and starts over. This lets software take one interrupt for a batch of completions instead of one interrupt per completion.

All registers are reached through a simple port with a select, a write strobe, write data and combinational read data.

Top module: `ic_irq_coalesce`

## Requirements
- R1: After reset the status, mask and delay registers read 0 and `irq_o` is low.
- R2: A done pulse on transmit queue q sets status bit q, and a done pulse on receive queue q sets status bit 16+q. Each bit reads 1 from the clock edge that samples the pulse onward.
- R3: A write to select 0 (status) clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: When a status bit is set by hardware in the same cycle that software writes 1 to clear it, the bit stays 1.
- R5: Select 1 is the mask register, which uses the same bit positions as status. `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R6: Select 2 is the delay register. Bits 15:0 configure receive coalescing and bits 31:16 configure transmit coalescing. Within each half, bit 15 is enable, bits 14:8 are the count threshold and bits 7:0 are the timeout. While a half's enable is 0, its delayed status bits are never set.
- R7: A cycle with one or more done pulses in a direction counts as one pending event. When an enabled unit with a non-zero threshold reaches the threshold, it sets its delayed-interrupt bit and its count-cause bit. For transmit these are bit 28 and bit 29; for receive they are bit 30 and bit 31.
- R8: While at least one event is pending, the timer advances once per prescaler tick, and a tick comes every TICK_DIV cycles. When the timer reaches a non-zero timeout, only the delayed-interrupt bit (28 or 30) is set. A timeout of T therefore fires between (T-1)*TICK_DIV+1 and T*TICK_DIV cycles after the first event.
- R9: A threshold of 0 disables the count cause and a timeout of 0 disables the timer cause. With both at 0, every event sets both the delayed-interrupt bit and the count-cause bit.
- R10: After a delayed interrupt fires, the pending count and the timer restart from zero, so the next count-caused interrupt needs a full threshold of new events.
- R11: Status and mask bits with no source (bits 27:18, 15:NUM_TXQ and 17:16+NUM_RXQ) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_i | input | NUM_TXQ | Per-queue transmit done pulses |
| rx_done_i | input | NUM_RXQ | Per-queue receive done pulses |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 delay |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt line |

## Verification
Two functions can act on the same status bit in the same cycle: a hardware set from a done pulse, and a software clear from a write-1 to the status register. The bench provokes this by driving a transmit done pulse in the same cycle as a status write. The write clears that bit and also clears a different, already-set bit. The judgement is that the colliding bit reads 1 afterwards while the other bit reads 0, so set wins only where both act. The timeout case is judged against a window one prescaler period wide, because the tick phase at the first event is free.

// File: rtl/ic_pkg.sv
package ic_pkg;
   localparam int REG_W      = 32;
   localparam int TXQ_LSB    = 0;
   localparam int RXQ_LSB    = 16;
   localparam int TX_DLY_INT = 28;
   localparam int TX_DLY_CNT = 29;
   localparam int RX_DLY_INT = 30;
   localparam int RX_DLY_CNT = 31;
   localparam int HALF_W     = 16;
   localparam int THR_W      = 7;
   localparam int TMO_W      = 8;

   // field order inside a 16-bit half: enable, threshold, timeout
   typedef struct packed {
      logic             en;
      logic [THR_W-1:0] thr;
      logic [TMO_W-1:0] tmo;
   } coal_cfg_t;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_DELAY  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ic_tick_gen.sv
module ic_tick_gen #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("ic_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (cnt_q == LAST)  cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      // R8
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/ic_coalesce.sv
module ic_coalesce
   import ic_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  coal_cfg_t cfg_i,
   input  logic      ev_i,
   input  logic      tick_i,
   output logic      fire_o,
   output logic      by_count_o
);
   logic [THR_W-1:0] cnt_q;
   logic [TMO_W-1:0] tmr_q;
   logic [THR_W-1:0] cnt_inc;
   logic             pend, thr_on, tmo_on, hit_cnt, hit_tmo;

   assign pend    = (cnt_q != '0);
   assign thr_on  = (cfg_i.thr != '0);
   assign tmo_on  = (cfg_i.tmo != '0);
   assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + THR_W'(ev_i);

   always_comb begin
      hit_cnt = 1'b0;
      if (cfg_i.en && ev_i) begin
         if (thr_on) hit_cnt = (cnt_inc >= cfg_i.thr);
         else        hit_cnt = !tmo_on;
      end
   end

   assign hit_tmo = cfg_i.en && tmo_on && pend && tick_i &&
                    (({1'b0, tmr_q} + 1'b1) >= {1'b0, cfg_i.tmo});

   assign fire_o     = hit_cnt || hit_tmo;
   assign by_count_o = hit_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !cfg_i.en || fire_o) begin
         cnt_q <= '0;
         tmr_q <= '0;
      end else begin
         cnt_q <= cnt_inc;
         if (pend && tick_i && tmo_on) tmr_q <= tmr_q + 1'b1;
      end
   end

   // R7
   thr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.en && ev_i && cfg_i.thr == THR_W'(1)) |-> (fire_o && by_count_o));

   // R8
   tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !ev_i) |-> tick_i);

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (cnt_q == '0 && tmr_q == '0));
endmodule

// File: rtl/ic_irq_coalesce.sv
module ic_irq_coalesce
   import ic_pkg::*;
#(
   parameter int NUM_TXQ  = 4,
   parameter int NUM_RXQ  = 2,
   parameter int TICK_DIV = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TXQ-1:0] tx_done_i,
   input  logic [NUM_RXQ-1:0] rx_done_i,
   input  logic [1:0]         reg_sel_i,
   input  logic               reg_we_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               irq_o
);
   if (NUM_TXQ < 1 || NUM_TXQ > 4) begin : g_bad_txq
      $error("ic_irq_coalesce: NUM_TXQ must be 1..4");
   end
   if (NUM_RXQ < 1 || NUM_RXQ > 2) begin : g_bad_rxq
      $error("ic_irq_coalesce: NUM_RXQ must be 1..2");
   end

   localparam logic [REG_W-1:0] TXQ_BITS = REG_W'((1 << NUM_TXQ) - 1) << TXQ_LSB;
   localparam logic [REG_W-1:0] RXQ_BITS = REG_W'((1 << NUM_RXQ) - 1) << RXQ_LSB;
   localparam logic [REG_W-1:0] IMPL     = 32'hF000_0000 | TXQ_BITS | RXQ_BITS;

   reg_sel_e         sel;
   logic [REG_W-1:0] sts_q, msk_q, dly_q;
   logic [REG_W-1:0] set_v, clr_v;
   logic [1:0]       fire_v, bycnt_v;
   logic             tick;

   assign sel = reg_sel_e'(reg_sel_i);

   ic_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   // direction 0 is receive (low half), direction 1 is transmit (high half)
   for (genvar d = 0; d < 2; d++) begin : g_dir
      coal_cfg_t cfg;
      logic      ev;
      if (d == 0) begin : g_rx
         assign cfg = coal_cfg_t'(dly_q[HALF_W-1:0]);
         assign ev  = |rx_done_i;
      end else begin : g_tx
         assign cfg = coal_cfg_t'(dly_q[REG_W-1:HALF_W]);
         assign ev  = |tx_done_i;
      end
      ic_coalesce u_coal (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_i      (cfg),
         .ev_i       (ev),
         .tick_i     (tick),
         .fire_o     (fire_v[d]),
         .by_count_o (bycnt_v[d])
      );
   end

   always_comb begin
      set_v = '0;
      set_v[TXQ_LSB +: NUM_TXQ] = tx_done_i;
      set_v[RXQ_LSB +: NUM_RXQ] = rx_done_i;
      set_v[RX_DLY_INT] = fire_v[0];
      set_v[RX_DLY_CNT] = fire_v[0] & bycnt_v[0];
      set_v[TX_DLY_INT] = fire_v[1];
      set_v[TX_DLY_CNT] = fire_v[1] & bycnt_v[1];
   end

   assign clr_v = (reg_we_i && sel == SEL_STATUS) ? reg_wdata_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         msk_q <= '0;
         dly_q <= '0;
      end else begin
         sts_q <= ((sts_q & ~clr_v) | set_v) & IMPL;
         if (reg_we_i && sel == SEL_MASK)  msk_q <= reg_wdata_i & IMPL;
         if (reg_we_i && sel == SEL_DELAY) dly_q <= reg_wdata_i;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_STATUS: reg_rdata_o = sts_q;
         SEL_MASK:   reg_rdata_o = msk_q;
         SEL_DELAY:  reg_rdata_o = dly_q;
         default:    reg_rdata_o = '0;
      endcase
   end

   assign irq_o = |(sts_q & msk_q);

   // R2
   direct_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done_i[0] |=> sts_q[TXQ_LSB]);

   // R2
   rx_direct_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_i[0] |=> sts_q[RXQ_LSB]);
endmodule

// File: tb/ic_irq_coalesce_tb.sv
module ic_irq_coalesce_tb_top;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tx_done = '0;
   logic [1:0]  rx_done = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   ic_irq_coalesce #(.NUM_TXQ(4), .NUM_RXQ(2), .TICK_DIV(DIV)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_done_i   (tx_done),
      .rx_done_i   (rx_done),
      .reg_sel_i   (reg_sel),
      .reg_we_i    (reg_we),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq)
   );

   // monitor: pops expected items and compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input logic [1:0] s, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_sel = s;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_sel = s; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse(input logic [3:0] t, input logic [1:0] r);
      @(negedge clk);
      tx_done = t; rx_done = r;
      @(negedge clk);
      tx_done = '0; rx_done = '0;
   endtask

   task automatic clear_and_pulse(input logic [31:0] c, input logic [3:0] t);
      @(negedge clk);
      reg_sel = 2'd0; reg_we = 1'b1; reg_wdata = c; tx_done = t;
      @(negedge clk);
      reg_we = 1'b0; tx_done = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg(2'd0, 32'h0, "R1 status");
      expect_reg(2'd1, 32'h0, "R1 mask");
      expect_reg(2'd2, 32'h0, "R1 delay");
      expect_irq(1'b0, "R1 irq");

      // R6 disabled coalescing, R2 direct bits
      pulse(4'b1001, 2'b01);
      expect_reg(2'd0, 32'h0001_0009, "R2/R6 direct bits only");

      // R3 partial clear
      wr(2'd0, 32'h0000_0008);
      expect_reg(2'd0, 32'h0001_0001, "R3 partial clear");

      // R4 set wins over clear on the same bit, other bit cleared
      clear_and_pulse(32'h0001_0001, 4'b0001);
      expect_reg(2'd0, 32'h0000_0001, "R4 set beats clear");

      // R5 mask gating
      wr(2'd1, 32'h0001_0000);
      expect_irq(1'b0, "R5 masked bit");
      pulse(4'b0000, 2'b01);
      expect_irq(1'b1, "R5 unmasked bit");
      wr(2'd0, 32'h0001_0000);
      expect_irq(1'b0, "R5 after clear");

      // R11 unimplemented bits
      wr(2'd1, 32'hFFFF_FFFF);
      expect_reg(2'd1, 32'hF003_000F, "R11 mask bits");
      expect_irq(1'b1, "R5 full mask");
      wr(2'd1, 32'h0);

      // R6 delay register readback
      wr(2'd2, 32'h8300_8000);
      expect_reg(2'd2, 32'h8300_8000, "R6 delay readback");
      wr(2'd2, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF);
      expect_reg(2'd0, 32'h0, "R3 full clear");

      // R7 count threshold 3 on transmit
      wr(2'd2, 32'h8300_0000);
      pulse(4'b0010, 2'b00);
      pulse(4'b0110, 2'b00);
      expect_reg(2'd0, 32'h0000_0006, "R7 below threshold");
      pulse(4'b0010, 2'b00);
      expect_reg(2'd0, 32'h3000_0006, "R7 threshold reached");

      // R10 restart after fire
      wr(2'd0, 32'hFFFF_FFFF);
      pulse(4'b0010, 2'b00);
      pulse(4'b0010, 2'b00);
      expect_reg(2'd0, 32'h0000_0002, "R10 count restarted");
      pulse(4'b0010, 2'b00);
      expect_reg(2'd0, 32'h3000_0002, "R10 refire");

      // R9 both zero on receive: fire per event
      wr(2'd2, 32'h0000_8000);
      wr(2'd0, 32'hFFFF_FFFF);
      pulse(4'b0000, 2'b10);
      expect_reg(2'd0, 32'hC002_0000, "R9 both zero fires");

      // R8 timeout 3 on transmit, threshold 0 (R9 count cause off)
      wr(2'd2, 32'h8003_0000);
      wr(2'd0, 32'hFFFF_FFFF);
      pulse(4'b0001, 2'b00);
      repeat (7) @(negedge clk);
      expect_reg(2'd0, 32'h0000_0001, "R8 not before window");
      repeat (3) @(negedge clk);
      expect_reg(2'd0, 32'h1000_0001, "R8 timeout fired");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule